// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block sits on the host side of an asynchronous 32K x 8 parallel read-only memory and turns a single request into one timed read cycle. The caller presents a 15-bit address with `req_i`. The request is taken when `ready_o` is high. The block then drives the address and pulls the active-low chip-select strobe down. It delays the active-low read-strobe by the largest whole number of clock cycles that still does not stretch the access.

After the access window has elapsed, the byte on the memory data bus is captured. The capture happens on the same edge that raises both strobes, so the byte is taken before the memory's output hold time runs out. The byte is returned with a one-cycle valid pulse. The data bus then stays reserved until the memory's output-float time has passed. Only after that may the bus be handed to another driver, or may the next read start.

All delays are given in nanoseconds and converted to clock cycles with a clock-period parameter. A speed-grade parameter selects between two timing sets:

- Fast grade: 45 ns access, 20 ns read-strobe-to-data, 20 ns float.
- Slow grade: 70 ns access, 30 ns read-strobe-to-data, 25 ns float.

Conversion rounds up, with a floor of one cycle per phase. The read-strobe lead time is the exception: it rounds down, and it may be zero.

Top module: `prom_rd_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the cycle after it is released, both strobes are high, `mem_addr_o` is zero, `rvalid_o` is low, and `ready_o` and `bus_free_o` are high. Asserting reset in the middle of an access returns the block to this state at once.
- R2: A request is accepted on a rising edge at which `req_i` and `ready_o` are both high. From the next cycle, `mem_ce_no` is low and `mem_addr_o` carries the accepted address. The address stays stable until the strobes rise.
- R3: `mem_oe_no` goes low OE_LEAD = floor((tACC - tOE) / period) cycles after `mem_ce_no` falls, and it is never low while `mem_ce_no` is high. At the default setting (fast grade, 20 ns clock) OE_LEAD is 1.
- R4: The byte on `mem_data_i` is captured into `rdata_o` at the edge that ends the access, with both strobes still low. That edge comes ACC_TOT cycles after `mem_ce_no` falls, where ACC_TOT = max(ceil(tACC / period), OE_LEAD + ceil(tOE / period)). Both strobes rise on that same edge, and `rvalid_o` is high from that edge on. At the default setting ACC_TOT is 3.
- R5: `rvalid_o` is high for exactly one cycle per accepted read. `rdata_o` holds its value until the next capture.
- R6: `ready_o` is low for the whole access. Changes of `addr_i`, and any `req_i` level, during that time do not alter `mem_addr_o`.
- R7: After the strobes rise, `mem_ce_no` stays high for at least FLOAT = ceil(tDF / period) cycles (1 at the default setting). A request pending at the end of the float interval is accepted on its final cycle, so that back-to-back reads leave a gap of exactly FLOAT cycles.
- R8: `bus_free_o` is high only when the block is idle and the float interval has elapsed. It stays low throughout a chain of back-to-back reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request |
| addr_i | input | 15 | Byte address of the request |
| ready_o | output | 1 | Request is accepted on this cycle's edge if `req_i` is high |
| rdata_o | output | 8 | Captured byte |
| rvalid_o | output | 1 | One-cycle pulse marking a new `rdata_o` |
| mem_addr_o | output | 15 | Memory address bus |
| mem_ce_no | output | 1 | Memory chip-select strobe, active low |
| mem_oe_no | output | 1 | Memory read strobe, active low |
| mem_data_i | input | 8 | Memory data bus |
| bus_free_o | output | 1 | Data bus released for other drivers |

## Verification
Two events can fall on one edge: the end of the float interval and the acceptance of the next request. This happens when `req_i` is already high as the float interval runs out. The bench provokes it by chaining reads, raising `req_i` for the next address on the same cycle that the previous read's valid pulse appears.

The bench then judges three things:

- the chip-select gap is exactly the float count;
- `bus_free_o` never rises between the chained reads;
- each byte matches the queued expectation.

The bus model only presents correct data once both strobe timings have been met. Because of that, an early capture or an early new cycle shows up as a data mismatch or a gap failure.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_FLOAT  = 2'd2
  } phase_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_phase_cnt.sv
module prom_phase_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             advance_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  // restart loads 1: the value then equals edges elapsed in the phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= CNT_W'(1);
    end else if (advance_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/prom_strobe_seq.sv
module prom_strobe_seq
  import prom_rd_pkg::*;
#(
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned OE_LEAD   = 1,
  parameter int unsigned ACC_TOT   = 3,
  parameter int unsigned FLOAT_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             restart_o,
  output logic             advance_o,
  output logic             launch_o,
  output logic             capture_o,
  output logic             ce_n_o,
  output logic             oe_n_o,
  output logic             ready_o,
  output logic             idle_o
);

  localparam logic [CNT_W-1:0] LeadCnt  = CNT_W'(OE_LEAD);
  localparam logic [CNT_W-1:0] AccCnt   = CNT_W'(ACC_TOT);
  localparam logic [CNT_W-1:0] FloatCnt = CNT_W'(FLOAT_CYC);
  localparam logic             OeAtLaunch = (OE_LEAD == 0) ? 1'b0 : 1'b1;

  phase_e phase_q, phase_d;
  logic   ce_n_q, ce_n_d;
  logic   oe_n_q, oe_n_d;
  logic   float_done;

  assign float_done = (phase_q == PH_FLOAT) && (count_i == FloatCnt);
  assign ready_o    = (phase_q == PH_IDLE) || float_done;
  assign launch_o   = ready_o && req_i;
  assign idle_o     = (phase_q == PH_IDLE);

  always_comb begin
    phase_d   = phase_q;
    ce_n_d    = ce_n_q;
    oe_n_d    = oe_n_q;
    restart_o = 1'b0;
    advance_o = 1'b0;
    capture_o = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          phase_d   = PH_ACCESS;
          ce_n_d    = 1'b0;
          oe_n_d    = OeAtLaunch;
          restart_o = 1'b1;
        end
      end
      PH_ACCESS: begin
        advance_o = 1'b1;
        if (count_i == LeadCnt) oe_n_d = 1'b0;
        if (count_i == AccCnt) begin
          capture_o = 1'b1;
          ce_n_d    = 1'b1;
          oe_n_d    = 1'b1;
          phase_d   = PH_FLOAT;
          restart_o = 1'b1;
        end
      end
      PH_FLOAT: begin
        advance_o = 1'b1;
        if (float_done) begin
          if (req_i) begin
            // float expiry and next launch share this edge
            phase_d   = PH_ACCESS;
            ce_n_d    = 1'b0;
            oe_n_d    = OeAtLaunch;
            restart_o = 1'b1;
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        ce_n_d  = 1'b1;
        oe_n_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
    end
  end

  assign ce_n_o = ce_n_q;
  assign oe_n_o = oe_n_q;

endmodule

// File: rtl/prom_rd_datapath.sv
module prom_rd_datapath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (launch_i) begin
      addr_q <= addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture_i;
      if (capture_i) data_q <= mem_data_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign rdata_o    = data_q;
  assign rvalid_o   = valid_q;

endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_rd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter bit          FAST_GRADE    = 1'b1,
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              bus_free_o
);

  localparam int unsigned T_ACC_NS  = FAST_GRADE ? 45 : 70;
  localparam int unsigned T_OE_NS   = FAST_GRADE ? 20 : 30;
  localparam int unsigned T_DF_NS   = FAST_GRADE ? 20 : 25;

  localparam int unsigned ACC_CYC   = at_least_one(ceil_div(T_ACC_NS, CLK_PERIOD_NS));
  localparam int unsigned OE_CYC    = at_least_one(ceil_div(T_OE_NS, CLK_PERIOD_NS));
  localparam int unsigned OE_LEAD   = (T_ACC_NS - T_OE_NS) / CLK_PERIOD_NS;
  localparam int unsigned ACC_TOT   = max_u(ACC_CYC, OE_LEAD + OE_CYC);
  localparam int unsigned FLOAT_CYC = at_least_one(ceil_div(T_DF_NS, CLK_PERIOD_NS));
  localparam int unsigned CNT_MAX   = max_u(ACC_TOT, FLOAT_CYC);
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] count;
  logic             restart, advance, launch, capture, idle;

  prom_phase_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .advance_i(advance),
    .count_o  (count)
  );

  prom_strobe_seq #(
    .CNT_W    (CNT_W),
    .OE_LEAD  (OE_LEAD),
    .ACC_TOT  (ACC_TOT),
    .FLOAT_CYC(FLOAT_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .count_i  (count),
    .restart_o(restart),
    .advance_o(advance),
    .launch_o (launch),
    .capture_o(capture),
    .ce_n_o   (mem_ce_no),
    .oe_n_o   (mem_oe_no),
    .ready_o  (ready_o),
    .idle_o   (idle)
  );

  prom_rd_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .addr_i    (addr_i),
    .capture_i (capture),
    .mem_data_i(mem_data_i),
    .mem_addr_o(mem_addr_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign bus_free_o = idle;

endmodule

// File: rtl/prom_rd_ctrl_chk.sv
module prom_rd_ctrl_chk #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned FLOAT_CYC = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_oe_no,
  input logic              bus_free_o
);

  localparam int unsigned GAP_W = $clog2(FLOAT_CYC + 2);
  localparam logic [GAP_W-1:0] GapSat = GAP_W'(FLOAT_CYC);

  // cycles chip-select has been high, saturating at the float count
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= GapSat;
    else if (!mem_ce_no) gap_q <= '0;
    else if (gap_q != GapSat) gap_q <= gap_q + GAP_W'(1);
  end

  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));

  a_r3_oe_inside_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_ce_no);

  a_r4_capture_with_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> $past(!mem_oe_no) && mem_ce_no);

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  a_r6_ready_strobes_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_ce_no && mem_oe_no));

  a_r7_float_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> (gap_q >= GapSat));

  a_r8_bus_free_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_free_o |-> (mem_ce_no && mem_oe_no && ready_o));

endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .FLOAT_CYC(FLOAT_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_o   (ready_o),
  .rvalid_o  (rvalid_o),
  .mem_addr_o(mem_addr_o),
  .mem_ce_no (mem_ce_no),
  .mem_oe_no (mem_oe_no),
  .bus_free_o(bus_free_o)
);

// File: tb/prom_rd_ctrl_bench.sv
module prom_rd_ctrl_bench;

  // expected timing at 20 ns clock, fast grade
  localparam int PER     = 20;
  localparam int CE_CYC  = (45 + PER - 1) / PER;
  localparam int OE_CYC  = (20 + PER - 1) / PER;
  localparam int LEAD    = (45 - 20) / PER;
  localparam int ACC_TOT = (CE_CYC > LEAD + OE_CYC) ? CE_CYC : LEAD + OE_CYC;
  localparam int FLOAT   = (20 + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic        ready_o, rvalid_o, mem_ce_no, mem_oe_no, bus_free_o;
  logic [7:0]  rdata_o;
  logic [14:0] mem_addr_o;
  logic [7:0]  mem_data_i = 8'hEE;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  prom_rd_ctrl u_prom_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_addr_o(mem_addr_o), .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no),
    .mem_data_i(mem_data_i), .bus_free_o(bus_free_o)
  );

  function automatic logic [7:0] rom_byte(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: valid byte only once both strobe timings are met
  int ce_run = 0;
  int oe_run = 0;
  always @(negedge clk) begin
    ce_run = mem_ce_no ? 0 : ce_run + 1;
    oe_run = mem_oe_no ? 0 : oe_run + 1;
    mem_data_i = (ce_run >= CE_CYC && oe_run >= OE_CYC) ? rom_byte(mem_addr_o) : 8'hEE;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected rvalid", 1, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rdata_o == e, "R4 captured byte", rdata_o, e);
      end
    end
  end

  // float gap monitor
  int  hi_run = 0;
  bit  seen_acc = 0;
  always @(negedge clk) begin
    if (!rst_ni) begin
      hi_run = 0;
      seen_acc = 0;
    end else if (mem_ce_no) begin
      hi_run++;
    end else begin
      if (seen_acc && hi_run > 0) check(hi_run >= FLOAT, "R7 float gap", hi_run, FLOAT);
      hi_run = 0;
      seen_acc = 1;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check_reset_state(input string tag);
    check(mem_ce_no && mem_oe_no, {tag, " strobes high"}, {mem_ce_no, mem_oe_no}, 3);
    check(mem_addr_o == 0, {tag, " address zero"}, mem_addr_o, 0);
    check(!rvalid_o, {tag, " rvalid low"}, rvalid_o, 0);
    check(ready_o && bus_free_o, {tag, " ready and bus_free"}, {ready_o, bus_free_o}, 3);
  endtask

  // called at a negedge; returns at the negedge after the capture edge
  task automatic do_read(input logic [14:0] a, input bit chained);
    req_i = 1'b1;
    addr_i = a;
    exp_q.push_back(rom_byte(a));
    if (chained) check(ready_o == 1'b1, "R7 back-to-back accept at float end", ready_o, 1);
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    req_i = 1'b0;
    addr_i = ~a;  // R6: must not reach the bus
    for (int k = 0; k < ACC_TOT; k++) begin
      check(!mem_ce_no, "R2 ce low during access", mem_ce_no, 0);
      check(mem_addr_o == a, "R6 address held", mem_addr_o, a);
      check(mem_oe_no == (k < LEAD), "R3 oe lead", mem_oe_no, (k < LEAD));
      check(!ready_o, "R6 ready low while busy", ready_o, 0);
      check(!bus_free_o, "R8 bus reserved", bus_free_o, 0);
      check(!rvalid_o, "R5 no early valid", rvalid_o, 0);
      @(negedge clk);
    end
    check(mem_ce_no && mem_oe_no, "R4 strobes rise at capture", {mem_ce_no, mem_oe_no}, 3);
    check(rvalid_o, "R4 valid after access", rvalid_o, 1);
    check(ready_o == (FLOAT == 1), "R7 ready at float end", ready_o, (FLOAT == 1));
    check(!bus_free_o, "R8 bus reserved during float", bus_free_o, 0);
  endtask

  task automatic wait_idle();
    for (int j = 1; j < FLOAT; j++) begin
      @(negedge clk);
      check(!bus_free_o && !ready_o, "R7 float not elapsed", {bus_free_o, ready_o}, 0);
    end
    @(negedge clk);
    check(bus_free_o, "R8 bus free after float", bus_free_o, 1);
    check(ready_o, "R8 ready when idle", ready_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state("R1 after release");

    do_read(15'h0000, 0); wait_idle();
    do_read(15'h7FFF, 0); wait_idle();
    do_read(15'h1234, 0);
    do_read(15'h4321, 1);
    do_read(15'h2AAA, 1);
    wait_idle();
    repeat (3) begin
      @(negedge clk);
      check(rdata_o == rom_byte(15'h2AAA), "R5 rdata holds", rdata_o, rom_byte(15'h2AAA));
      check(!rvalid_o, "R5 valid single pulse", rvalid_o, 0);
    end

    // R1: reset in the middle of an access
    req_i = 1'b1;
    addr_i = 15'h0ABC;
    @(negedge clk);
    req_i = 1'b0;
    check(!mem_ce_no, "R2 access started", mem_ce_no, 0);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_reset_state("R1 mid-access reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state("R1 after mid-access reset");

    do_read(15'h5555, 0); wait_idle();
    do_read(15'h0001, 0);
    for (int i = 1; i < 8; i++) do_read(15'(i * 4099), 1);
    wait_idle();
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5 every read returned", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule